// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds eight 32-bit general registers and lets each one be accessed as a whole word, as its lower half, or, for the first four registers, as one of two bytes inside that lower half. Narrow views are aliases of the wide register and not separate storage. A narrow write therefore merges into the 32-bit word and leaves every bit outside the addressed slice untouched.

The block has two combinational read ports and one write port. Each port takes a slot index and a view code. Read data is always zero-extended to 32 bits. A write is committed on the rising clock edge. A byte-view write aimed at a register with no byte views is dropped, and a reject output flags it in the same cycle.

The register file is meant to sit in the operand stage of an execution pipeline. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `alias_regfile`

## Requirements
- R1: While reset is held, and after it is released, every register reads as zero through a full-word view until it is first written.
- R2: A write with view code 2'b00 (full word) replaces all 32 bits of the selected slot.
- R3: A write with view code 2'b01 (half) loads wr_data[15:0] into bits 15:0 and keeps bits 31:16 of the slot.
- R4: A write with view code 2'b10 (low byte) to slots 0 to 3 loads wr_data[7:0] into bits 7:0 and keeps bits 31:8.
- R5: A write with view code 2'b11 (high byte) to slots 0 to 3 loads wr_data[7:0] into bits 15:8 and keeps bits 31:16 and 7:0.
- R6: A write with view code 2'b10 or 2'b11 to slots 4 to 7 changes no register and drives wr_reject high in that cycle. In every other cycle wr_reject is low. A write never alters any slot other than its target.
- R7: Reads are zero-extended. The half view returns bits 15:0, the low-byte view returns bits 7:0, and the high-byte view returns bits 15:8, each placed at bit 0 of the read data.
- R8: A byte-view read (code 2'b10 or 2'b11) of slots 4 to 7 returns zero.
- R9: A read of the slot being written in the same cycle returns the value held before that write.
- R10: The two read ports decode their index and view independently of each other and of the write port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write slot index |
| wr_view | input | 2 | Write view code |
| wr_data | input | 32 | Write data; narrow views take the low bits |
| wr_reject | output | 1 | Write refused for an illegal byte view |
| rd_idx_a | input | 3 | Read port A slot index |
| rd_view_a | input | 2 | Read port A view code |
| rd_data_a | output | 32 | Read port A data, zero-extended |
| rd_idx_b | input | 3 | Read port B slot index |
| rd_view_b | input | 2 | Read port B view code |
| rd_data_b | output | 32 | Read port B data, zero-extended |

## Verification
The assertions assume that wr_en, wr_idx, wr_view and wr_data are stable across each rising edge. They also assume that no write is offered while the internal synchronised reset is still asserted, which takes two edges after rst_n rises. The stimulus changes inputs only on falling edges, and it waits three rising edges after releasing reset before its first write. The random phase deliberately covers illegal byte views on the upper four slots and same-slot read-and-write collisions, and a behavioural model predicts the effect of both.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [1:0] {
    VIEW_FULL = 2'b00,
    VIEW_HALF = 2'b01,
    VIEW_LOB  = 2'b10,
    VIEW_HIB  = 2'b11
  } view_e;

  function automatic logic is_byte_view(input logic [1:0] v);
    return v[1];
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/slice_merge.sv
module slice_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [1:0]        view,
  output logic [DATA_W-1:0] merged
);
  import regfile_pkg::*;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;

  always_comb begin
    merged = old_val;
    unique case (view)
      VIEW_FULL: merged = new_val;
      VIEW_HALF: merged[HALF_W-1:0] = new_val[HALF_W-1:0];
      VIEW_LOB:  merged[BYTE_W-1:0] = new_val[BYTE_W-1:0];
      VIEW_HIB:  merged[2*BYTE_W-1:BYTE_W] = new_val[BYTE_W-1:0];
      default:   merged = old_val;
    endcase
  end
endmodule

// File: rtl/view_extract.sv
module view_extract #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [$clog2(NUM_REGS)-1:0]     idx,
  input  logic [1:0]                      view,
  output logic [DATA_W-1:0]               data
);
  import regfile_pkg::*;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] word;
  logic              byte_ok;

  assign word    = regs[idx];
  assign byte_ok = (int'(idx) < BYTE_REGS);

  always_comb begin
    data = '0;
    unique case (view)
      VIEW_FULL: data = word;
      VIEW_HALF: data[HALF_W-1:0] = word[HALF_W-1:0];
      VIEW_LOB:  if (byte_ok) data[BYTE_W-1:0] = word[BYTE_W-1:0];
      VIEW_HIB:  if (byte_ok) data[BYTE_W-1:0] = word[2*BYTE_W-1:BYTE_W];
      default:   data = '0;
    endcase
  end

  // R7: a narrow view never returns bits above the lower half
  always_comb begin
    if (view != VIEW_FULL)
      assert_narrow_zero_ext_R7: assert (data[DATA_W-1:HALF_W] == '0);
  end
endmodule

// File: rtl/reg_store.sv
module reg_store #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4
) (
  input  logic                            clk,
  input  logic                            rst_int_n,
  input  logic                            wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]     wr_idx,
  input  logic [1:0]                      wr_view,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            wr_reject,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  import regfile_pkg::*;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;

  logic              wr_ok;
  logic [DATA_W-1:0] merged;
  logic [NUM_REGS-1:0] we_vec;

  assign wr_ok = wr_en && !wr_reject;

  slice_merge #(.DATA_W(DATA_W)) u_merge (
    .old_val (regs_q[wr_idx]),
    .new_val (wr_data),
    .view    (wr_view),
    .merged  (merged)
  );

  always_comb begin
    we_vec = '0;
    if (wr_ok) we_vec[wr_idx] = 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)     regs_q[i] <= '0;
      else if (we_vec[i]) regs_q[i] <= merged;
    end

    assert_untouched_slot_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
      !(wr_en && !wr_reject && int'(wr_idx) == i) |=> $stable(regs_q[i]));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en && !wr_reject && int'(wr_idx) == i && wr_view == VIEW_FULL)
      |=> regs_q[i] == $past(wr_data));

    assert_half_merge_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en && !wr_reject && int'(wr_idx) == i && wr_view == VIEW_HALF)
      |=> (regs_q[i][DATA_W-1:HALF_W] == $past(regs_q[i][DATA_W-1:HALF_W]))
       && (regs_q[i][HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

    assert_high_byte_merge_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en && !wr_reject && int'(wr_idx) == i && wr_view == VIEW_HIB)
      |=> (regs_q[i][2*BYTE_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0]))
       && (regs_q[i][BYTE_W-1:0] == $past(regs_q[i][BYTE_W-1:0]))
       && (regs_q[i][DATA_W-1:HALF_W] == $past(regs_q[i][DATA_W-1:HALF_W])));
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int NUM_RD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_view,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_reject,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [1:0]        rd_view_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  input  logic [1:0]        rd_view_b,
  output logic [DATA_W-1:0] rd_data_b
);
  import regfile_pkg::*;

  logic                            rst_int_n;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][1:0]          rd_view;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign wr_reject = wr_en && is_byte_view(wr_view) && (int'(wr_idx) >= BYTE_REGS);

  reg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_store (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_view   (wr_view),
    .wr_data   (wr_data),
    .wr_reject (wr_reject),
    .regs_q    (regs_q)
  );

  assign rd_idx  = {rd_idx_b, rd_idx_a};
  assign rd_view = {rd_view_b, rd_view_a};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    view_extract #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_view (
      .regs (regs_q),
      .idx  (rd_idx[p]),
      .view (rd_view[p]),
      .data (rd_data[p])
    );
  end

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];

  // R6: a rejected write never coincides with a change of any slot
  assert_reject_holds_state_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_reject |=> $stable(regs_q));

  // R1: registers stay cleared while the synchronised reset is active
  always_comb begin
    if (!rst_int_n)
      assert_reset_clear_R1: assert (regs_q == '0);
  end
endmodule

// File: tb/alias_regfile_tb.sv
module alias_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_view;
  logic [31:0] wr_data;
  logic        wr_reject;
  logic [2:0]  rd_idx_a, rd_idx_b;
  logic [1:0]  rd_view_a, rd_view_b;
  logic [31:0] rd_data_a, rd_data_b;

  int unsigned model [8];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alias_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
    .wr_reject(wr_reject),
    .rd_idx_a(rd_idx_a), .rd_view_a(rd_view_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_view_b(rd_view_b), .rd_data_b(rd_data_b)
  );

  function automatic int unsigned exp_read(int idx, int view);
    int unsigned w = model[idx];
    case (view)
      0: return w;
      1: return w & 32'h0000_FFFF;
      2: return (idx < 4) ? (w & 32'h0000_00FF) : 0;
      default: return (idx < 4) ? ((w >> 8) & 32'h0000_00FF) : 0;
    endcase
  endfunction

  function automatic bit exp_reject(bit en, int idx, int view);
    return en && (view >= 2) && (idx >= 4);
  endfunction

  task automatic check(string tag, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check before the rising edge, update model after it.
  task automatic step(string tag, bit en, int wi, int wv, int unsigned wd,
                      int ra, int va, int rb, int vb);
    @(negedge clk);
    wr_en = en; wr_idx = 3'(wi); wr_view = 2'(wv); wr_data = wd;
    rd_idx_a = 3'(ra); rd_view_a = 2'(va); rd_idx_b = 3'(rb); rd_view_b = 2'(vb);
    #1;
    check(tag, "rd_data_a", rd_data_a, exp_read(ra, va));
    check(tag, "rd_data_b", rd_data_b, exp_read(rb, vb));
    check(tag, "wr_reject", 32'(wr_reject), 32'(exp_reject(en, wi, wv)));
    @(posedge clk);
    #1;
    if (en && !exp_reject(en, wi, wv)) begin
      case (wv)
        0: model[wi] = wd;
        1: model[wi] = (model[wi] & 32'hFFFF_0000) | (wd & 32'h0000_FFFF);
        2: model[wi] = (model[wi] & 32'hFFFF_FF00) | (wd & 32'h0000_00FF);
        default: model[wi] = (model[wi] & 32'hFFFF_00FF) | ((wd & 32'hFF) << 8);
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
    rd_idx_a = '0; rd_view_a = '0; rd_idx_b = '0; rd_view_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "in-reset slot0", rd_data_a, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: all slots read zero after reset
    for (int i = 0; i < 8; i += 2) step("R1", 0, 0, 0, 0, i, 0, i + 1, 0);
    // R2: full write
    step("R2", 1, 0, 0, 32'h1122_3344, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 1);
    // R3: half write keeps the upper half
    step("R3", 1, 1, 0, 32'hAABB_CCDD, 1, 0, 1, 0);
    step("R3", 1, 1, 1, 32'hFFFF_5566, 1, 0, 1, 1);
    step("R3", 0, 0, 0, 0, 1, 0, 1, 1);
    // R4: low-byte write
    step("R4", 1, 2, 0, 32'hCAFE_F00D, 2, 0, 2, 2);
    step("R4", 1, 2, 2, 32'h1234_5677, 2, 0, 2, 2);
    step("R4", 0, 0, 0, 0, 2, 0, 2, 3);
    // R5: high-byte write
    step("R5", 1, 3, 0, 32'h1234_5678, 3, 0, 3, 3);
    step("R5", 1, 3, 3, 32'h0000_009A, 3, 0, 3, 3);
    step("R5", 0, 0, 0, 0, 3, 0, 3, 2);
    // R6: byte writes to slots 4..7 are rejected
    step("R6", 1, 5, 0, 32'hDEAD_BEEF, 5, 0, 6, 0);
    step("R6", 1, 6, 0, 32'h0BAD_F00D, 5, 0, 6, 0);
    step("R6", 1, 5, 2, 32'h0000_0011, 5, 0, 6, 0);
    step("R6", 1, 6, 3, 32'h0000_0022, 5, 0, 6, 0);
    step("R6", 1, 4, 3, 32'h0000_0033, 4, 0, 7, 0);
    step("R6", 0, 0, 0, 0, 5, 0, 6, 0);
    // R7: zero-extended narrow views
    step("R7", 0, 0, 0, 0, 0, 1, 0, 2);
    step("R7", 0, 0, 0, 0, 0, 3, 5, 1);
    // R8: byte views of slots 4..7 read zero
    step("R8", 0, 0, 0, 0, 5, 2, 5, 3);
    step("R8", 0, 0, 0, 0, 6, 2, 6, 3);
    // R9: same-cycle read returns the old value
    step("R9", 1, 0, 0, 32'h5555_AAAA, 0, 0, 0, 1);
    step("R9", 1, 0, 3, 32'h0000_0077, 0, 0, 0, 3);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 3);
    // R10: random mix on both read ports
    for (int n = 0; n < 3000; n++)
      step("R10", 1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom, $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 7), $urandom_range(0, 3));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule